// File: doc/BRIEF.md
# Two-Level Audio Interrupt Aggregator

This block collects error and event pulses from the buffer engines of an audio subsystem and reduces them to one interrupt line. There are five event groups. Each group has one latched status bit per port and a mask bit per port. Groups 0, 1 and 3 cover four playback ports: FIFO underflow, ring-buffer underflow and the free-mark event. Groups 2 and 4 cover three capture ports: ring-buffer overflow and the full-mark event. A status bit records its event whether or not it is masked. The mask decides only whether the group reports upward.

A second level holds one latched summary bit per group. A summary bit is set while its group has any status bit that is not masked. The summary level has its own clear and mask controls. The interrupt output is high while any summary bit is set and not masked in the summary mask.

Software reaches every register through a small single-cycle register port. Reads are combinational. Status is cleared by writing ones. Mask bits are changed only by write-one set and write-one clear aliases.

Top module: `audio_irq_agg`

## Requirements
- R1: After reset every status bit and summary bit is 0. Every mask bit, in the groups and in the summary, is 1. `irq_o` is 0.
- R2: A one-cycle pulse on event lane `evt_i[4*g+p]` sets status bit p of group g at the next clock edge. This happens even when that bit's mask is 1.
- R3: Writing a 1 to bit p of a group's clear register (kind 1) clears status bit p. Bits written as 0 keep their value.
- R4: Writing ones to the mask-set alias (kind 3) sets those mask bits. Writing ones to the mask-clear alias (kind 4) clears them. Zeros in either write leave the mask unchanged. The mask view (kind 2) reads the current mask.
- R5: Groups 0, 1 and 3 use lanes 0 to 3. Groups 2 and 4 use lanes 0 to 2. An event on lane 3 of a capture group is ignored, and that status bit always reads 0.
- R6: Summary bit g is set at the clock edge after group g holds a status bit that is not masked. Summary bit g then stays set until it is cleared through the summary clear register. A clear has no effect while that group condition still holds.
- R7: `irq_o` is 1 exactly when some summary bit is set and its summary mask bit is 0.
- R8: If an event and a clear of the same status bit occur in the same cycle, the bit ends up set. Other bits cleared in the same write are cleared.
- R9: Address encoding: `reg_addr_i[5:3]` selects a group (0 to 4) or the summary (5), and `reg_addr_i[2:0]` selects the register kind (0 status, 1 clear, 2 mask view, 3 mask set, 4 mask clear). Writes to kinds 0 and 2 have no effect. Reads of kinds 1, 3 and 4, and of unused group codes, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 20 | Event pulses, 4 lanes per group; group g uses bits 4g+3..4g |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address: group select in bits 5:3, kind in bits 2:0 |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
A single-lane pulse is walked across every lane of every group with all masks set. This shows that each status bit latches independently of its mask, and that the capture groups discard their fourth lane. Each pulse is followed by a zero-clear and then a one-clear, to separate write-one-to-clear behaviour from a plain overwrite.

With all groups pending, all 32 summary-mask patterns are swept, so the interrupt must follow the unmasked summary bits exactly. A clear of a summary bit whose group is still unmasked-pending is checked to have no effect. Event/clear collisions on the same lane and on neighbouring lanes show that the event has priority without blocking the other bits of the clear.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

   localparam int NUM_GRP = 5;
   localparam int KIND_W  = 3;
   localparam int GSEL_W  = 3;
   localparam int SUM_SEL = NUM_GRP;

   typedef enum logic [KIND_W-1:0] {
      RK_STAT = 3'd0,
      RK_CLR  = 3'd1,
      RK_MASK = 3'd2,
      RK_MSET = 3'd3,
      RK_MCLR = 3'd4
   } reg_kind_e;

   // capture groups are ring-buffer overflow (2) and full mark (4)
   function automatic bit grp_is_capture(int g);
      return (g == 2) || (g == 4);
   endfunction

   function automatic logic [31:0] lane_valid(int g, int play_n, int cap_n);
      int n;
      n = grp_is_capture(g) ? cap_n : play_n;
      return (32'd1 << n) - 32'd1;
   endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int           W     = 4,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr_we,
   input  logic         mset_we,
   input  logic         mclr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] stat_o,
   output logic [W-1:0] mask_o,
   output logic         pend_o
);

   logic [W-1:0] stat_q;
   logic [W-1:0] mask_q;
   logic [W-1:0] clr_bits;
   logic [W-1:0] set_bits;
   logic [W-1:0] unset_bits;

   assign clr_bits   = clr_we  ? wdata : '0;
   assign set_bits   = mset_we ? wdata : '0;
   assign unset_bits = mclr_we ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         // event term is ORed last so it wins over a same-cycle clear
         stat_q <= (stat_q & ~clr_bits) | (evt & VALID);
         mask_q <= (mask_q | set_bits) & ~unset_bits;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign pend_o = |(stat_q & ~mask_q);

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
   parameter int NUM_GRP = 5,
   parameter int PORT_W  = 4,
   parameter int DATA_W  = 8,
   parameter int GSEL_W  = 3,
   parameter int KIND_W  = 3
) (
   input  logic [GSEL_W-1:0]         gsel,
   input  logic [KIND_W-1:0]         kind,
   input  logic [NUM_GRP*PORT_W-1:0] stat_flat,
   input  logic [NUM_GRP*PORT_W-1:0] mask_flat,
   input  logic [NUM_GRP-1:0]        sum_stat,
   input  logic [NUM_GRP-1:0]        sum_mask,
   output logic [DATA_W-1:0]         rdata
);
   import audio_irq_pkg::*;

   always_comb begin
      rdata = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (int'(gsel) == g) begin
            if (kind == RK_STAT) rdata[PORT_W-1:0] = stat_flat[g*PORT_W +: PORT_W];
            if (kind == RK_MASK) rdata[PORT_W-1:0] = mask_flat[g*PORT_W +: PORT_W];
         end
      end
      if (int'(gsel) == NUM_GRP) begin
         if (kind == RK_STAT) rdata[NUM_GRP-1:0] = sum_stat;
         if (kind == RK_MASK) rdata[NUM_GRP-1:0] = sum_mask;
      end
   end

endmodule

// File: rtl/audio_irq_agg.sv
module audio_irq_agg #(
   parameter int PORT_W     = 4,
   parameter int PLAY_PORTS = 4,
   parameter int CAP_PORTS  = 3,
   parameter int DATA_W     = 8
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic [audio_irq_pkg::NUM_GRP*PORT_W-1:0]   evt_i,
   input  logic                                       reg_wr_i,
   input  logic [audio_irq_pkg::GSEL_W+audio_irq_pkg::KIND_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0]                          reg_wdata_i,
   output logic [DATA_W-1:0]                          reg_rdata_o,
   output logic                                       irq_o
);
   import audio_irq_pkg::*;

   localparam int FLAT_W = NUM_GRP * PORT_W;
   localparam int ADDR_W = GSEL_W + KIND_W;

   // elaboration-time parameter checks
   if (PLAY_PORTS > PORT_W || CAP_PORTS > PORT_W) begin : g_bad_ports
      $error("port count exceeds lane width");
   end
   if (PORT_W > DATA_W || NUM_GRP > DATA_W) begin : g_bad_data
      $error("register width too small");
   end
   if ((1 << GSEL_W) <= NUM_GRP) begin : g_bad_gsel
      $error("group select too narrow");
   end

   logic [GSEL_W-1:0] gsel;
   logic [KIND_W-1:0] kind;
   logic [FLAT_W-1:0] stat_flat;
   logic [FLAT_W-1:0] mask_flat;
   logic [NUM_GRP-1:0] grp_pend;
   logic [NUM_GRP-1:0] sum_stat;
   logic [NUM_GRP-1:0] sum_mask;
   logic               sum_pend;

   assign gsel = reg_addr_i[ADDR_W-1:KIND_W];
   assign kind = reg_addr_i[KIND_W-1:0];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic hit;
      assign hit = reg_wr_i && (int'(gsel) == g);

      irq_status_bank #(
         .W     (PORT_W),
         .VALID (PORT_W'(lane_valid(g, PLAY_PORTS, CAP_PORTS)))
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (evt_i[g*PORT_W +: PORT_W]),
         .clr_we  (hit && kind == RK_CLR),
         .mset_we (hit && kind == RK_MSET),
         .mclr_we (hit && kind == RK_MCLR),
         .wdata   (reg_wdata_i[PORT_W-1:0]),
         .stat_o  (stat_flat[g*PORT_W +: PORT_W]),
         .mask_o  (mask_flat[g*PORT_W +: PORT_W]),
         .pend_o  (grp_pend[g])
      );
   end

   logic sum_hit;
   assign sum_hit = reg_wr_i && (int'(gsel) == SUM_SEL);

   irq_status_bank #(
      .W     (NUM_GRP),
      .VALID ('1)
   ) u_summary (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (grp_pend),
      .clr_we  (sum_hit && kind == RK_CLR),
      .mset_we (sum_hit && kind == RK_MSET),
      .mclr_we (sum_hit && kind == RK_MCLR),
      .wdata   (reg_wdata_i[NUM_GRP-1:0]),
      .stat_o  (sum_stat),
      .mask_o  (sum_mask),
      .pend_o  (sum_pend)
   );

   assign irq_o = sum_pend;

   irq_rd_mux #(
      .NUM_GRP (NUM_GRP),
      .PORT_W  (PORT_W),
      .DATA_W  (DATA_W),
      .GSEL_W  (GSEL_W),
      .KIND_W  (KIND_W)
   ) u_rd (
      .gsel      (gsel),
      .kind      (kind),
      .stat_flat (stat_flat),
      .mask_flat (mask_flat),
      .sum_stat  (sum_stat),
      .sum_mask  (sum_mask),
      .rdata     (reg_rdata_o)
   );

endmodule

// File: rtl/audio_irq_agg_chk.sv
module audio_irq_agg_chk #(
   parameter int PORT_W     = 4,
   parameter int PLAY_PORTS = 4,
   parameter int CAP_PORTS  = 3
) (
   input logic                                     clk,
   input logic                                     rst_n,
   input logic                                     reg_wr_i,
   input logic [audio_irq_pkg::NUM_GRP*PORT_W-1:0] evt_i,
   input logic [audio_irq_pkg::NUM_GRP*PORT_W-1:0] stat_flat,
   input logic [audio_irq_pkg::NUM_GRP*PORT_W-1:0] mask_flat,
   input logic [audio_irq_pkg::NUM_GRP-1:0]        sum_stat,
   input logic [audio_irq_pkg::NUM_GRP-1:0]        sum_mask,
   input logic                                     irq_o
);
   import audio_irq_pkg::*;

   localparam int FLAT_W = NUM_GRP * PORT_W;

   function automatic logic [FLAT_W-1:0] all_valid();
      logic [FLAT_W-1:0] v;
      v = '0;
      for (int g = 0; g < NUM_GRP; g++)
         v[g*PORT_W +: PORT_W] = PORT_W'(lane_valid(g, PLAY_PORTS, CAP_PORTS));
      return v;
   endfunction

   localparam logic [FLAT_W-1:0] VALID_ALL = all_valid();

   logic [FLAT_W-1:0]  evt_v;
   logic [NUM_GRP-1:0] pend_model;

   assign evt_v = evt_i & VALID_ALL;

   always_comb begin
      for (int g = 0; g < NUM_GRP; g++)
         pend_model[g] = |(stat_flat[g*PORT_W +: PORT_W] & ~mask_flat[g*PORT_W +: PORT_W]);
   end

   AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_v != '0) |=> ((stat_flat & $past(evt_v)) == $past(evt_v))); // R2

   AST_NO_SPONT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_flat & ~$past(stat_flat) & ~$past(evt_v)) == '0)); // R3

   AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_i |=> ($stable(mask_flat) && $stable(sum_mask))); // R4

   AST_UNUSED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_flat & ~VALID_ALL) == '0)); // R5

   AST_SUM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((sum_stat & ~$past(sum_stat) & ~$past(pend_model)) == '0)); // R6

   AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (&sum_mask) |-> !irq_o); // R7

endmodule

bind audio_irq_agg audio_irq_agg_chk #(
   .PORT_W     (PORT_W),
   .PLAY_PORTS (PLAY_PORTS),
   .CAP_PORTS  (CAP_PORTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr_i  (reg_wr_i),
   .evt_i     (evt_i),
   .stat_flat (stat_flat),
   .mask_flat (mask_flat),
   .sum_stat  (sum_stat),
   .sum_mask  (sum_mask),
   .irq_o     (irq_o)
);

// File: tb/audio_irq_agg_test.sv
`timescale 1ns/1ps
module audio_irq_agg_test;

   localparam int K_STAT = 0, K_CLR = 1, K_MASK = 2, K_MSET = 3, K_MCLR = 4;
   localparam int SUMG = 5;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [19:0] evt_i = '0;
   logic        reg_wr_i = 0;
   logic [5:0]  reg_addr_i = '0;
   logic [7:0]  reg_wdata_i = '0;
   logic [7:0]  reg_rdata_o;
   logic        irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   audio_irq_agg uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
      .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
   );

   function automatic int valid_of(int g);
      return (g == 2 || g == 4) ? 'h7 : 'hF;
   endfunction

   task automatic chk(string rq, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=0x%0h exp=0x%0h", rq, act, exp);
      end
   endtask

   task automatic wr(int g, int k, int d);
      @(negedge clk);
      reg_addr_i  = {g[2:0], k[2:0]};
      reg_wdata_i = d[7:0];
      reg_wr_i    = 1;
      @(negedge clk);
      reg_wr_i    = 0;
   endtask

   task automatic rd(int g, int k, output int v);
      reg_addr_i = {g[2:0], k[2:0]};
      #0.5;
      v = int'(reg_rdata_o);
   endtask

   task automatic pulse(logic [19:0] e);
      @(negedge clk);
      evt_i = e;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic evt_and_clear(int g, logic [19:0] e, int d);
      @(negedge clk);
      evt_i       = e;
      reg_addr_i  = {g[2:0], 3'(K_CLR)};
      reg_wdata_i = d[7:0];
      reg_wr_i    = 1;
      @(negedge clk);
      evt_i    = '0;
      reg_wr_i = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      for (int g = 0; g < 5; g++) begin
         rd(g, K_STAT, v); chk("R1 status", v, 0);
         rd(g, K_MASK, v); chk("R1 mask", v, 'hF);
      end
      rd(SUMG, K_STAT, v); chk("R1 summary", v, 0);
      rd(SUMG, K_MASK, v); chk("R1 summary mask", v, 'h1F);
      chk("R1 irq", int'(irq_o), 0);

      // R2/R5/R3 sweep of every lane with masks set
      for (int g = 0; g < 5; g++) begin
         for (int p = 0; p < 4; p++) begin
            int e;
            e = ((valid_of(g) >> p) & 1) << p;
            pulse(20'(1) << (4*g + p));
            rd(g, K_STAT, v); chk("R2 R5 lane latch", v, e);
            @(negedge clk);
            rd(SUMG, K_STAT, v); chk("R6 masked group", v, 0);
            chk("R7 irq masked", int'(irq_o), 0);
            wr(g, K_CLR, 0);
            rd(g, K_STAT, v); chk("R3 zero clear", v, e);
            wr(g, K_CLR, 1 << p);
            rd(g, K_STAT, v); chk("R3 one clear", v, 0);
         end
      end

      // R4 mask aliases on group 1
      wr(1, K_MCLR, 'h5); rd(1, K_MASK, v); chk("R4 mask clear", v, 'hA);
      wr(1, K_MSET, 'h1); rd(1, K_MASK, v); chk("R4 mask set", v, 'hB);
      wr(1, K_MCLR, 0);   rd(1, K_MASK, v); chk("R4 zero clear", v, 'hB);
      wr(1, K_MSET, 0);   rd(1, K_MASK, v); chk("R4 zero set", v, 'hB);

      // R6 summary latching (group 1 lane 1 masked, lane 2 unmasked)
      pulse(20'(1) << 5);
      @(negedge clk);
      rd(SUMG, K_STAT, v); chk("R6 masked lane no summary", v, 0);
      wr(1, K_CLR, 'h2);
      pulse(20'(1) << 6);
      @(negedge clk);
      rd(SUMG, K_STAT, v); chk("R6 summary set", v, 'h2);
      chk("R7 irq summary masked", int'(irq_o), 0);
      wr(SUMG, K_CLR, 'h2);
      rd(SUMG, K_STAT, v); chk("R6 clear while pending", v, 'h2);
      wr(1, K_CLR, 'h4);
      @(negedge clk);
      rd(SUMG, K_STAT, v); chk("R6 latched after group clear", v, 'h2);
      wr(SUMG, K_CLR, 'h2);
      rd(SUMG, K_STAT, v); chk("R6 summary cleared", v, 0);

      // R7 sweep of all summary mask patterns with every group pending
      for (int g = 0; g < 5; g++) wr(g, K_MCLR, 'hF);
      pulse('1);
      @(negedge clk);
      rd(SUMG, K_STAT, v); chk("R6 all groups", v, 'h1F);
      rd(2, K_STAT, v); chk("R5 capture lane3 ignored", v, 'h7);
      for (int m = 0; m < 32; m++) begin
         wr(SUMG, K_MSET, 'h1F);
         wr(SUMG, K_MCLR, m);
         rd(SUMG, K_MASK, v); chk("R4 summary mask", v, 'h1F & ~m);
         chk("R7 irq sweep", int'(irq_o), (m != 0) ? 1 : 0);
      end
      wr(2, K_CLR, 'hF);
      @(negedge clk);
      wr(SUMG, K_CLR, 'h4);
      rd(SUMG, K_STAT, v); chk("R6 group2 summary cleared", v, 'h1B);
      wr(SUMG, K_MSET, 'h1F);
      wr(SUMG, K_MCLR, 'h4);
      chk("R7 only cleared bit unmasked", int'(irq_o), 0);

      // R8 collisions on group 0
      wr(0, K_CLR, 'hF);
      rd(0, K_STAT, v); chk("R3 full clear", v, 0);
      evt_and_clear(0, 20'h1, 'h1);
      rd(0, K_STAT, v); chk("R8 event beats clear", v, 'h1);
      evt_and_clear(0, 20'h2, 'h1);
      rd(0, K_STAT, v); chk("R8 other bit cleared", v, 'h2);

      // R9 read-only views and unused codes
      wr(3, K_STAT, 0);
      rd(3, K_STAT, v); chk("R9 status write ignored", v, 'hF);
      wr(3, K_MASK, 'hF);
      rd(3, K_MASK, v); chk("R9 mask view write ignored", v, 0);
      rd(3, K_CLR, v);  chk("R9 clear reads zero", v, 0);
      rd(3, K_MSET, v); chk("R9 set alias reads zero", v, 0);
      rd(6, K_STAT, v); chk("R9 unused group reads zero", v, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule